// File: doc/BRIEF.md
# Multichannel Power-Good Delay Controller

This block produces one active-low power-good output for each monitored supply rail. Each rail has an external comparator that reports a digital undervoltage flag. A rail's output drops in the same cycle its flag goes high. The output comes back high only after the rail has stayed good for a fixed number of tick periods. The outputs can drive the enable pins of downstream regulators, so that rails come up in order.

Three global controls act on every channel:
- A force input pulls every output low.
- An active-low freeze input holds all outputs and hold-off timers exactly where they are.
- A power-up lockout input holds everything low, and it overrides the other two controls.

A 5-bit threshold selection code is captured once, when the lockout first goes away after reset. It is then presented unchanged to the threshold logic outside this block.

All timing counts a free-running tick input, not raw clock cycles. A bench can therefore run a shortened hold-off without changing the logic.

Top module: `pgood_delay_ctrl`

## Requirements
- R1: While lockout is low and freeze_n is high, a channel whose undervoltage flag is 1 drives its pg_n bit to 0 in the same cycle, with no clock edge needed.
- R2: After the flag of a channel returns to 0, pg_n stays 0 until HOLD_TICKS clock edges with tick high have been seen with the channel good, and goes to 1 on that edge; edges with tick low are not counted.
- R3: If the flag of a channel goes to 1 again during its hold-off, its count restarts from zero and the output stays 0 for a further full HOLD_TICKS ticks.
- R4: Driving force_low to 1 pulls every pg_n bit to 0 in the same cycle (when lockout is low and freeze_n is high).
- R5: When force_low returns to 0, every channel waits its full HOLD_TICKS ticks before its pg_n bit goes to 1.
- R6: While freeze_n is 0 and lockout is 0, every pg_n bit and every hold-off count keeps its value whatever uv_flag and force_low do.
- R7: When freeze_n returns to 1, each channel continues its hold-off from the count it had when frozen, rather than restarting.
- R8: While lockout is 1, every pg_n bit is 0 and every count is cleared, even while freeze_n is 0.
- R9: sel_code_q reads 0 until the first clock edge after reset with lockout low. On that edge it takes the value of sel_code. Later changes of sel_code have no effect on it.
- R10: While rst_n is 0, every pg_n bit is 0 and sel_code_q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse; one hold-off count per clock edge with tick high |
| uv_flag | input | NUM_CH | Per-channel undervoltage flag, 1 = rail below threshold |
| force_low | input | 1 | 1 forces all power-good outputs low |
| freeze_n | input | 1 | 0 holds all outputs and timers at their present state |
| lockout | input | 1 | 1 during power-up; holds all outputs low |
| sel_code | input | SEL_W | Threshold selection code, captured once |
| pg_n | output | NUM_CH | Active-low power-good outputs, 0 = rail not good |
| sel_code_q | output | SEL_W | Captured threshold selection code |

## Verification
The following are checked by assertions on every cycle:
- Lockout always wins over every other control.
- A flagged channel or a forced state shows low at the outputs.
- A frozen channel keeps its outputs and count stable.
- An undervoltage event or a lockout clears the count.
- An output rises only on the final counted tick.
- The captured code is stable once it has been taken.

Some behaviour depends on a sequence of events, so only the bench scenarios can show it:
- The exact release edge after HOLD_TICKS ticks, with dense and with sparse ticks.
- The restart of the count after a dip in the middle of a hold-off.
- The count resuming, not restarting, after a freeze.
- The code value captured when lockout ends, and its immunity to later changes of the code.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

  // Width of a counter that must hold values 0 .. limit-1.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // True when the current count plus this tick completes the hold-off.
  function automatic logic hold_expired(input int unsigned count,
                                        input logic        tick,
                                        input int unsigned limit);
    return tick && (count + 1 >= limit);
  endfunction

  // Next count value while a channel is good and waiting.
  function automatic int unsigned next_count(input int unsigned count,
                                             input logic        tick);
    return tick ? count + 1 : count;
  endfunction

  typedef struct packed {
    logic lock;
    logic freeze;
    logic force_on;
  } glob_ctrl_t;

endpackage

// File: rtl/pgood_ctrl_decode.sv
module pgood_ctrl_decode
  import pgood_pkg::*;
(
  input  logic       force_low,
  input  logic       freeze_n,
  input  logic       lockout,
  output glob_ctrl_t ctrl
);
  // Lockout dominates; freeze dominates force.
  always_comb begin
    ctrl.lock     = lockout;
    ctrl.freeze   = !lockout && !freeze_n;
    ctrl.force_on = !lockout && freeze_n && force_low;
  end
endmodule

// File: rtl/pgood_sel_capture.sv
module pgood_sel_capture #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lockout,
  input  logic [SEL_W-1:0] sel_code,
  output logic [SEL_W-1:0] sel_code_q,
  output logic             captured
);
  wire take_now = !captured && !lockout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_code_q <= '0;
      captured   <= 1'b0;
    end else if (take_now) begin
      sel_code_q <= sel_code;
      captured   <= 1'b1;
    end
  end

  p_code_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable(sel_code_q));

  p_no_capture_in_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!captured && lockout) |=> !captured);
endmodule

// File: rtl/pgood_channel.sv
module pgood_channel
  import pgood_pkg::*;
#(
  parameter int HOLD_TICKS = 625,
  localparam int CNT_W     = cnt_width(HOLD_TICKS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       uv,
  input  glob_ctrl_t ctrl,
  output logic       pg_n_o
);
  logic             pg_q;
  logic [CNT_W-1:0] cnt;

  // Named internal events for the checks.
  wire fault     = uv || ctrl.force_on;
  wire waiting   = !pg_q && !fault && !ctrl.freeze && !ctrl.lock;
  wire hold_done = waiting && hold_expired(int'(cnt), tick, HOLD_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      cnt  <= '0;
    end else if (ctrl.lock) begin
      pg_q <= 1'b0;
      cnt  <= '0;
    end else if (ctrl.freeze) begin
      pg_q <= pg_q;
      cnt  <= cnt;
    end else if (fault) begin
      pg_q <= 1'b0;
      cnt  <= '0;
    end else if (hold_done) begin
      pg_q <= 1'b1;
      cnt  <= '0;
    end else if (waiting) begin
      cnt  <= CNT_W'(next_count(int'(cnt), tick));
    end
  end

  // Output: immediate pull-down on fault, stored state while frozen.
  always_comb begin
    if (ctrl.lock)        pg_n_o = 1'b0;
    else if (ctrl.freeze) pg_n_o = pg_q;
    else                  pg_n_o = pg_q && !fault;
  end

  p_release_on_last_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> ($past(cnt) == CNT_W'(HOLD_TICKS-1) && $past(tick)));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < HOLD_TICKS);

  p_dip_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uv && !ctrl.freeze && !ctrl.lock) |=> (cnt == '0 && !pg_q));

  p_freeze_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.freeze |=> ($stable(cnt) && $stable(pg_q)));

  p_lock_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.lock |=> (cnt == '0 && !pg_q));
endmodule

// File: rtl/pgood_delay_ctrl.sv
module pgood_delay_ctrl
  import pgood_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int HOLD_TICKS = 625,
  parameter int SEL_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NUM_CH-1:0] uv_flag,
  input  logic              force_low,
  input  logic              freeze_n,
  input  logic              lockout,
  input  logic [SEL_W-1:0]  sel_code,
  output logic [NUM_CH-1:0] pg_n,
  output logic [SEL_W-1:0]  sel_code_q
);
  glob_ctrl_t ctrl;
  logic       sel_taken;

  pgood_ctrl_decode u_ctrl (
    .force_low (force_low),
    .freeze_n  (freeze_n),
    .lockout   (lockout),
    .ctrl      (ctrl)
  );

  pgood_sel_capture #(.SEL_W(SEL_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .lockout    (lockout),
    .sel_code   (sel_code),
    .sel_code_q (sel_code_q),
    .captured   (sel_taken)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pgood_channel #(.HOLD_TICKS(HOLD_TICKS)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .uv     (uv_flag[ch]),
      .ctrl   (ctrl),
      .pg_n_o (pg_n[ch])
    );
  end

  p_uv_pulls_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout && freeze_n) |-> ((pg_n & uv_flag) == '0));

  p_force_all_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout && freeze_n && force_low) |-> (pg_n == '0));

  p_freeze_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout && !freeze_n && $past(!lockout && !freeze_n)) |-> $stable(pg_n));

  p_lock_all_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (pg_n == '0));

  always_comb begin
    if (!rst_n) begin
      a_reset_low_r10: assert (pg_n == '0 && sel_code_q == '0);
    end
  end
endmodule

// File: tb/pgood_delay_ctrl_tb.sv
module pgood_delay_ctrl_tb_top;
  localparam int NCH  = 8;
  localparam int HOLD = 6;
  localparam int SW   = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b1;
  logic [NCH-1:0] uv_flag = '0;
  logic           force_low = 1'b0;
  logic           freeze_n = 1'b1;
  logic           lockout = 1'b1;
  logic [SW-1:0]  sel_code = 5'h13;
  logic [NCH-1:0] pg_n;
  logic [SW-1:0]  sel_code_q;

  int checks = 0;
  int errors = 0;
  logic sparse = 1'b0;
  int   tdiv = 0;

  always #5 clk = ~clk;

  pgood_delay_ctrl #(.NUM_CH(NCH), .HOLD_TICKS(HOLD), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv_flag),
    .force_low(force_low), .freeze_n(freeze_n), .lockout(lockout),
    .sel_code(sel_code), .pg_n(pg_n), .sel_code_q(sel_code_q)
  );

  // Sparse tick generator: one pulse every third cycle when enabled.
  always @(posedge clk) begin
    #1;
    if (sparse) begin
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      tick = (tdiv == 0);
    end else begin
      tick = 1'b1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R10 pg_n in reset", 32'(pg_n), 32'h00);
    chk("R10 sel in reset", 32'(sel_code_q), 32'h00);
    step(2);
    rst_n = 1'b1;
    step(3);
    chk("R8 lockout holds low", 32'(pg_n), 32'h00);
    chk("R9 no capture during lockout", 32'(sel_code_q), 32'h00);
  endtask

  task automatic t_powerup;
    lockout = 1'b0;
    step(1);
    chk("R9 captured at lockout end", 32'(sel_code_q), 32'h13);
    step(HOLD-2);
    chk("R2 still low before hold-off", 32'(pg_n), 32'h00);
    step(1);
    chk("R2 released after hold-off", 32'(pg_n), 32'hFF);
    sel_code = 5'h0A;
    step(2);
    chk("R9 later code ignored", 32'(sel_code_q), 32'h13);
  endtask

  task automatic t_uv_immediate;
    uv_flag[2] = 1'b1;
    #1;
    chk("R1 immediate assert", 32'(pg_n), 32'hFB);
    step(1);
    uv_flag[2] = 1'b0;
    step(HOLD-1);
    chk("R2 channel 2 still in hold-off", 32'(pg_n), 32'hFB);
    step(1);
    chk("R2 channel 2 released", 32'(pg_n), 32'hFF);
  endtask

  task automatic t_restart;
    uv_flag[5] = 1'b1;
    step(1);
    uv_flag[5] = 1'b0;
    step(3);
    uv_flag[5] = 1'b1;
    step(1);
    uv_flag[5] = 1'b0;
    step(HOLD-1);
    chk("R3 restarted hold-off", 32'(pg_n), 32'hDF);
    step(1);
    chk("R3 release after full restart", 32'(pg_n), 32'hFF);
  endtask

  task automatic t_force;
    force_low = 1'b1;
    #1;
    chk("R4 force all low", 32'(pg_n), 32'h00);
    step(2);
    force_low = 1'b0;
    step(HOLD-1);
    chk("R5 full hold-off after force", 32'(pg_n), 32'h00);
    step(1);
    chk("R5 release after force", 32'(pg_n), 32'hFF);
  endtask

  task automatic t_freeze;
    uv_flag[1] = 1'b1;
    step(1);
    uv_flag[1] = 1'b0;
    step(2);
    freeze_n = 1'b0;
    step(10);
    chk("R6 frozen low channel", 32'(pg_n), 32'hFD);
    uv_flag[0] = 1'b1;
    force_low = 1'b1;
    #1;
    chk("R6 uv and force ignored while frozen", 32'(pg_n), 32'hFD);
    step(2);
    uv_flag[0] = 1'b0;
    force_low = 1'b0;
    freeze_n = 1'b1;
    step(HOLD-3);
    chk("R7 resumed count not done", 32'(pg_n), 32'hFD);
    step(1);
    chk("R7 resumed count completes", 32'(pg_n), 32'hFF);
  endtask

  task automatic t_lock_over_freeze;
    freeze_n = 1'b0;
    lockout = 1'b1;
    #1;
    chk("R8 lockout overrides freeze", 32'(pg_n), 32'h00);
    step(2);
    lockout = 1'b0;
    freeze_n = 1'b1;
    step(HOLD-1);
    chk("R8 counts cleared by lockout", 32'(pg_n), 32'h00);
    step(1);
    chk("R8 release after lockout", 32'(pg_n), 32'hFF);
    chk("R9 code unchanged after second lockout", 32'(sel_code_q), 32'h13);
  endtask

  task automatic t_sparse;
    sparse = 1'b1;
    step(3);
    uv_flag[3] = 1'b1;
    step(1);
    uv_flag[3] = 1'b0;
    step(3*HOLD - 6);
    chk("R2 sparse ticks not yet done", 32'(pg_n), 32'hF7);
    step(9);
    chk("R2 sparse ticks released", 32'(pg_n), 32'hFF);
    sparse = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_powerup();
        t_uv_immediate();
        t_restart();
        t_force();
        t_freeze();
        t_lock_over_freeze();
        t_sparse();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule